// File: doc/BRIEF.md
# Dual-Width Integer Execution Unit

This block is the purely combinational arithmetic stage of a processor with a 64-bit register file. For each instruction it receives the decoded 4-bit operation code, a mode bit that chooses between 32-bit and 64-bit arithmetic, a bit that chooses between the source register and the immediate as second operand, the 16-bit offset field, the 32-bit immediate and the current contents of the destination and source registers. It returns the value to be written back to the destination register, together with a flag for encodings it does not accept.

The supported operations are the usual integer set: add, subtract, multiply, unsigned and signed divide and remainder, bitwise or/and/xor, left, logical right and arithmetic right shift, negate, plain and sign-extending move, and byte-order conversion. Division or remainder by zero never traps; both have a defined result. The host byte order is a build parameter and decides whether a given byte-order conversion reverses bytes or only truncates.

Top module: `alu_dw`

## Requirements
- R1: Operation codes are ADD 0x0, SUB 0x1, MUL 0x2, OR 0x4, AND 0x5, NEG 0x8 (result is 0 minus destination), XOR 0xA; all wrap on overflow; with `wide`=0 the result is formed from the low 32 bits of the operands and bits 63:32 of `result` are zero.
- R2: With `use_reg`=1 the second operand is `src_val`; with `use_reg`=0 it is `imm` sign-extended from bit 31 to 64 bits (in both modes and for every operation that reads it, including the unsigned divide and remainder).
- R3: DIV (0x3) and MOD (0x9) with `offset`=0 are unsigned; a zero divisor makes DIV return zero.
- R4: MOD with a zero divisor returns `dst_val` unchanged when `wide`=1 and `dst_val` with bits 63:32 cleared when `wide`=0.
- R5: DIV and MOD with `offset`=1 are signed, the quotient truncates toward zero and the remainder takes the sign of the dividend; the most negative value divided by -1 gives the most negative value and a remainder of zero.
- R6: LSH 0x6, RSH 0x7 and ARSH 0xC shift the destination by the second operand masked to 6 bits (`wide`=1) or 5 bits (`wide`=0); ARSH fills with the sign bit of the operand width.
- R7: MOV 0xB with `offset`=0 copies the second operand; `offset` 8 or 16 sign-extends its low 8 or 16 bits; `offset` 32 sign-extends its low 32 bits and is accepted only with `wide`=1.
- R8: END 0xD acts on `dst_val`, with `imm` giving the width 16, 32 or 64; with `wide`=1 it always reverses the bytes of that width; with `wide`=0 `use_reg`=0 targets little-endian and `use_reg`=1 big-endian, reversing bytes when the target differs from `HOST_BIG_ENDIAN` and otherwise keeping the low bytes of that width; either way bits above the width are zero and the 32-bit upper clearing of R1 does not apply.
- R9: Codes 0xE and 0xF, a non-zero `offset` on any operation not listed in R5/R7, any other `offset` on DIV/MOD/MOV, an END width other than 16/32/64 or a non-zero `offset` on END, and END with `wide`=1 and `use_reg`=1 all raise `illegal_op` and make `result` equal `dst_val`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 4 | Decoded operation code |
| wide | input | 1 | 1 = 64-bit arithmetic, 0 = 32-bit arithmetic |
| use_reg | input | 1 | Second-operand select; byte-order target for 32-bit END |
| offset | input | 16 | Offset field: signed-variant and extension-width selector |
| imm | input | 32 | Immediate operand; width selector for END |
| dst_val | input | 64 | Current destination register value |
| src_val | input | 64 | Current source register value |
| result | output | 64 | New destination value |
| illegal_op | output | 1 | Encoding not accepted; result holds dst_val |

## Verification
Every operation code, including the two unused ones, is applied in both widths with six offset values, against a grid of destination values that contains zero, one, all ones and the most negative 32-bit and 64-bit numbers, paired once with register sources and once with immediates. The grid separates unsigned from signed division at sign boundaries, exposes the most-negative-by-minus-one case in both widths, and the immediates 16, 32 and 64 double as END widths while -1 and 0x80000000 show whether immediate sign extension happens. Two instances with opposite host byte order run side by side so that swap-versus-truncate selection for END is told apart from plain byte reversal.

// File: rtl/alu_dw_pkg.sv
// Shared widths, operation encodings and byte reversal helper for the
// dual-width execution unit. Assumes a 64-bit datapath split in two halves.
package alu_dw_pkg;

    localparam int DATA_W = 64;
    localparam int HALF_W = DATA_W / 2;
    localparam int IMM_W  = 32;
    localparam int OFF_W  = 16;
    localparam int OP_W   = 4;
    localparam int NBYTES = DATA_W / 8;
    localparam int SH_W   = $clog2(DATA_W);

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_MUL  = 4'h2,
        OP_DIV  = 4'h3,
        OP_OR   = 4'h4,
        OP_AND  = 4'h5,
        OP_LSH  = 4'h6,
        OP_RSH  = 4'h7,
        OP_NEG  = 4'h8,
        OP_MOD  = 4'h9,
        OP_XOR  = 4'hA,
        OP_MOV  = 4'hB,
        OP_ARSH = 4'hC,
        OP_END  = 4'hD
    } op_e;

    typedef enum logic [1:0] {
        SW_16 = 2'd0,
        SW_32 = 2'd1,
        SW_64 = 2'd2
    } swap_w_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_LOGIC = 2'd1,
        SH_ARITH = 2'd2
    } shift_e;

    // Reverse the bytes of the low 16/32/64 bits; bits above the width are zero.
    function automatic logic [DATA_W-1:0] reverse_bytes(input logic [DATA_W-1:0] v,
                                                        input swap_w_e w);
        logic [DATA_W-1:0] full;
        for (int i = 0; i < NBYTES; i++) begin
            full[i*8 +: 8] = v[(NBYTES-1-i)*8 +: 8];
        end
        case (w)
            SW_16:   reverse_bytes = full >> (DATA_W - 16);
            SW_32:   reverse_bytes = full >> (DATA_W - 32);
            default: reverse_bytes = full;
        endcase
    endfunction

endpackage

// File: rtl/alu_dw_divider.sv
// Combinational quotient and remainder for unsigned or signed operands of
// 32 or 64 bits. Works on magnitudes and restores signs afterwards, so the
// most negative value divided by -1 wraps. A zero divisor yields quotient 0
// and remainder equal to the dividend; the caller applies its own policy.
module alu_dw_divider
    import alu_dw_pkg::*;
(
    input  logic [DATA_W-1:0] num,
    input  logic [DATA_W-1:0] den,
    input  logic              wide,
    input  logic              is_signed,
    output logic [DATA_W-1:0] quo,
    output logic [DATA_W-1:0] rem
);

    logic [DATA_W-1:0] num_x, den_x, mag_n, mag_d, uq, ur;
    logic              neg_n, neg_d;

    // Widen 32-bit operands by sign or zero according to the signedness.
    always_comb begin
        if (wide) begin
            num_x = num;
            den_x = den;
        end else if (is_signed) begin
            num_x = {{HALF_W{num[HALF_W-1]}}, num[HALF_W-1:0]};
            den_x = {{HALF_W{den[HALF_W-1]}}, den[HALF_W-1:0]};
        end else begin
            num_x = {{HALF_W{1'b0}}, num[HALF_W-1:0]};
            den_x = {{HALF_W{1'b0}}, den[HALF_W-1:0]};
        end
    end

    // Take magnitudes, divide unsigned, then restore the signs.
    always_comb begin
        neg_n = is_signed & num_x[DATA_W-1];
        neg_d = is_signed & den_x[DATA_W-1];
        mag_n = neg_n ? (~num_x + 1'b1) : num_x;
        mag_d = neg_d ? (~den_x + 1'b1) : den_x;
        if (mag_d == '0) begin
            uq = '0;
            ur = mag_n;
        end else begin
            uq = mag_n / mag_d;
            ur = mag_n % mag_d;
        end
        quo = (neg_n ^ neg_d) ? (~uq + 1'b1) : uq;
        rem = neg_n ? (~ur + 1'b1) : ur;
    end

endmodule

// File: rtl/alu_dw_shifter.sv
// Left, logical right and arithmetic right shift in 32- or 64-bit mode.
// The amount is masked to the mode's width; 32-bit results are zero-extended.
module alu_dw_shifter
    import alu_dw_pkg::*;
(
    input  logic [DATA_W-1:0] val,
    input  logic [SH_W-1:0]   amt,
    input  logic              wide,
    input  shift_e            kind,
    output logic [DATA_W-1:0] res
);

    logic [HALF_W-1:0] low_res;
    logic [SH_W-2:0]   amt_lo;

    // Select the width and direction of the shift.
    always_comb begin
        amt_lo  = amt[SH_W-2:0];
        low_res = '0;
        res     = '0;
        if (wide) begin
            case (kind)
                SH_LEFT:  res = val << amt;
                SH_LOGIC: res = val >> amt;
                default:  res = $unsigned($signed(val) >>> amt);
            endcase
        end else begin
            case (kind)
                SH_LEFT:  low_res = val[HALF_W-1:0] << amt_lo;
                SH_LOGIC: low_res = val[HALF_W-1:0] >> amt_lo;
                default:  low_res = $unsigned($signed(val[HALF_W-1:0]) >>> amt_lo);
            endcase
            res = {{HALF_W{1'b0}}, low_res};
        end
    end

    // Arithmetic shift of a negative value stays negative in its width.
    always_comb begin
        if (kind == SH_ARITH && !$isunknown({val, wide})) begin
            if (wide && val[DATA_W-1]) begin
                assert_arsh_sign_R6: assert (res[DATA_W-1])
                    else $error("arith shift lost sign (64)");
            end
            if (!wide && val[HALF_W-1]) begin
                assert_arsh_sign32_R6: assert (res[HALF_W-1] && res[DATA_W-1:HALF_W] == '0)
                    else $error("arith shift lost sign (32)");
            end
        end
    end

endmodule

// File: rtl/alu_dw_endian.sv
// Byte-order conversion of the destination value. In 64-bit mode the bytes
// of the chosen width are always reversed; in 32-bit mode they are reversed
// only when the requested order differs from the host order, otherwise the
// low bytes of that width are kept. Bits above the width become zero.
module alu_dw_endian
    import alu_dw_pkg::*;
#(
    parameter bit HOST_BIG_ENDIAN = 1'b0
) (
    input  logic [DATA_W-1:0] val,
    input  swap_w_e           width,
    input  logic              wide,
    input  logic              to_big,
    output logic [DATA_W-1:0] res
);

    logic              do_swap;
    logic [DATA_W-1:0] kept;

    // The host order picks which request is a no-op reorder.
    generate
        if (HOST_BIG_ENDIAN) begin : g_host_big
            assign do_swap = wide | ~to_big;
        end else begin : g_host_little
            assign do_swap = wide | to_big;
        end
    endgenerate

    // Truncate to the width when no reversal is needed.
    always_comb begin
        case (width)
            SW_16:   kept = {{(DATA_W-16){1'b0}}, val[15:0]};
            SW_32:   kept = {{(DATA_W-32){1'b0}}, val[31:0]};
            default: kept = val;
        endcase
        res = do_swap ? reverse_bytes(val, width) : kept;
    end

endmodule

// File: rtl/alu_dw.sv
// Dual-width integer execution unit. Decodes the operation, checks that the
// offset/immediate/source combination is accepted, forms the second operand,
// gathers the results of the sub-units and applies the 32-bit upper clearing.
// Purely combinational; assumes inputs are stable for the whole cycle.
module alu_dw
    import alu_dw_pkg::*;
#(
    parameter bit HOST_BIG_ENDIAN = 1'b0
) (
    input  logic [OP_W-1:0]   op_code,
    input  logic              wide,
    input  logic              use_reg,
    input  logic [OFF_W-1:0]  offset,
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    output logic [DATA_W-1:0] result,
    output logic              illegal_op
);

    localparam logic [OFF_W-1:0] OFF_SIGNED = OFF_W'(1);
    localparam logic [OFF_W-1:0] OFF_X8     = OFF_W'(8);
    localparam logic [OFF_W-1:0] OFF_X16    = OFF_W'(16);
    localparam logic [OFF_W-1:0] OFF_X32    = OFF_W'(32);

    op_e               op;
    logic [DATA_W-1:0] opnd_b, quo, rem, shifted, swapped, raw;
    logic              legal, off_zero, width_ok, divisor_zero, keep_full;
    shift_e            sh_kind;
    swap_w_e           sw_width;

    // Second operand: register or sign-extended immediate.
    always_comb begin
        opnd_b = use_reg ? src_val : {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
        op     = op_e'(op_code);
    end

    // Decode END width and shift direction.
    always_comb begin
        width_ok = 1'b1;
        case (imm)
            IMM_W'(16): sw_width = SW_16;
            IMM_W'(32): sw_width = SW_32;
            IMM_W'(64): sw_width = SW_64;
            default: begin
                sw_width = SW_64;
                width_ok = 1'b0;
            end
        endcase
        case (op)
            OP_LSH:  sh_kind = SH_LEFT;
            OP_RSH:  sh_kind = SH_LOGIC;
            default: sh_kind = SH_ARITH;
        endcase
        divisor_zero = wide ? (opnd_b == '0) : (opnd_b[HALF_W-1:0] == '0);
    end

    // Accept or reject the encoding.
    always_comb begin
        off_zero = (offset == '0);
        case (op)
            OP_ADD, OP_SUB, OP_MUL, OP_OR, OP_AND, OP_LSH,
            OP_RSH, OP_NEG, OP_XOR, OP_ARSH:
                legal = off_zero;
            OP_DIV, OP_MOD:
                legal = off_zero || (offset == OFF_SIGNED);
            OP_MOV:
                legal = off_zero || (offset == OFF_X8) || (offset == OFF_X16) ||
                        ((offset == OFF_X32) && wide);
            OP_END:
                legal = off_zero && width_ok && !(wide && use_reg);
            default:
                legal = 1'b0;
        endcase
    end

    alu_dw_divider u_div (
        .num       (dst_val),
        .den       (opnd_b),
        .wide      (wide),
        .is_signed (offset == OFF_SIGNED),
        .quo       (quo),
        .rem       (rem)
    );

    alu_dw_shifter u_shift (
        .val  (dst_val),
        .amt  (opnd_b[SH_W-1:0]),
        .wide (wide),
        .kind (sh_kind),
        .res  (shifted)
    );

    alu_dw_endian #(
        .HOST_BIG_ENDIAN (HOST_BIG_ENDIAN)
    ) u_endian (
        .val    (dst_val),
        .width  (sw_width),
        .wide   (wide),
        .to_big (use_reg),
        .res    (swapped)
    );

    // Pick the raw 64-bit result of the decoded operation.
    always_comb begin
        keep_full = 1'b0;
        case (op)
            OP_ADD:  raw = dst_val + opnd_b;
            OP_SUB:  raw = dst_val - opnd_b;
            OP_MUL:  raw = dst_val * opnd_b;
            OP_DIV:  raw = divisor_zero ? '0 : quo;
            OP_MOD:  raw = divisor_zero ? dst_val : rem;
            OP_OR:   raw = dst_val | opnd_b;
            OP_AND:  raw = dst_val & opnd_b;
            OP_XOR:  raw = dst_val ^ opnd_b;
            OP_NEG:  raw = '0 - dst_val;
            OP_LSH, OP_RSH, OP_ARSH:
                     raw = shifted;
            OP_MOV: begin
                case (offset)
                    OFF_X8:  raw = {{(DATA_W-8){opnd_b[7]}}, opnd_b[7:0]};
                    OFF_X16: raw = {{(DATA_W-16){opnd_b[15]}}, opnd_b[15:0]};
                    OFF_X32: raw = {{(DATA_W-32){opnd_b[31]}}, opnd_b[31:0]};
                    default: raw = opnd_b;
                endcase
            end
            OP_END: begin
                raw       = swapped;
                keep_full = 1'b1;
            end
            default: raw = dst_val;
        endcase
    end

    // Final write-back value with 32-bit upper clearing.
    always_comb begin
        illegal_op = ~legal;
        if (!legal)
            result = dst_val;
        else if (!wide && !keep_full)
            result = {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
        else
            result = raw;
    end

    // Rules that tie the output to the decode and to the divider's inputs.
    always_comb begin
        if (!$isunknown({op_code, wide, use_reg, offset, imm})) begin
            if (illegal_op) begin
                assert_illegal_hold_R9: assert (result == dst_val)
                    else $error("rejected encoding changed the destination");
            end
            if (!illegal_op && op == OP_DIV && divisor_zero) begin
                assert_div_zero_R3: assert (result == '0)
                    else $error("divide by zero not zero");
            end
            if (!illegal_op && op == OP_MOD && divisor_zero) begin
                assert_mod_zero_R4: assert (result == (wide ? dst_val :
                                            {{HALF_W{1'b0}}, dst_val[HALF_W-1:0]}))
                    else $error("remainder by zero wrong");
            end
            if (!illegal_op && !wide && op != OP_END) begin
                assert_upper_clear_R1: assert (result[DATA_W-1:HALF_W] == '0)
                    else $error("32-bit result has upper bits set");
            end
        end
    end

endmodule

// File: tb/alu_dw_test.sv
// Near-exhaustive sweep of the dual-width execution unit: every code, both
// widths, several offsets, a grid of corner operands, and both host orders.
module alu_dw_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic [3:0]  op_code;
    logic        wide, use_reg;
    logic [15:0] offset;
    logic [31:0] imm;
    logic [63:0] dst_val, src_val;
    logic [63:0] res_le, res_be;
    logic        ill_le, ill_be;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_dw #(.HOST_BIG_ENDIAN(1'b0)) uut (
        .op_code (op_code), .wide (wide), .use_reg (use_reg), .offset (offset),
        .imm (imm), .dst_val (dst_val), .src_val (src_val),
        .result (res_le), .illegal_op (ill_le)
    );

    alu_dw #(.HOST_BIG_ENDIAN(1'b1)) uut_be (
        .op_code (op_code), .wide (wide), .use_reg (use_reg), .offset (offset),
        .imm (imm), .dst_val (dst_val), .src_val (src_val),
        .result (res_be), .illegal_op (ill_be)
    );

    localparam logic [63:0] DST_SET [8] = '{64'h0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF,
        64'h8000_0000_0000_0000, 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_8000_0000,
        64'h1234_5678_9ABC_DEF0, 64'hFEDC_BA98_7654_3210};
    localparam logic [63:0] SRC_SET [8] = '{64'h0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF,
        64'h8000_0000_0000_0000, 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_8000_0000,
        64'h1234_5678_9ABC_DEF0, 64'h0000_0000_0000_0041};
    localparam logic [31:0] IMM_SET [8] = '{32'h0, 32'h1, 32'd16, 32'd32, 32'd64,
        32'hFFFF_FFFF, 32'h8000_0000, 32'h1234_5678};
    localparam logic [15:0] OFF_SET [6] = '{16'd0, 16'd1, 16'd8, 16'd16, 16'd32, 16'd3};

    // Reference model written from the requirements; returns {illegal, value}.
    function automatic logic [64:0] model(input logic [3:0] op, input bit w64,
            input bit ur, input logic [15:0] off, input logic [31:0] im,
            input logic [63:0] d, input logic [63:0] s, input bit host_be);
        logic [63:0] b, r;
        logic [31:0] d32, b32;
        longint      x, y;
        int          x32, y32, nb;
        bit          bad, sgn, swap;
        b   = ur ? s : {{32{im[31]}}, im};
        d32 = d[31:0];
        b32 = b[31:0];
        bad = (off != 16'd0);
        sgn = (off == 16'd1);
        r   = 64'h0;
        case (op)
            4'h0: r = w64 ? d + b : {32'h0, d32 + b32};
            4'h1: r = w64 ? d - b : {32'h0, d32 - b32};
            4'h2: r = w64 ? d * b : {32'h0, d32 * b32};
            4'h4: r = w64 ? (d | b) : {32'h0, d32 | b32};
            4'h5: r = w64 ? (d & b) : {32'h0, d32 & b32};
            4'hA: r = w64 ? (d ^ b) : {32'h0, d32 ^ b32};
            4'h8: r = w64 ? 64'h0 - d : {32'h0, 32'h0 - d32};
            4'h6: r = w64 ? d << b[5:0] : {32'h0, d32 << b[4:0]};
            4'h7: r = w64 ? d >> b[5:0] : {32'h0, d32 >> b[4:0]};
            4'hC: r = w64 ? $unsigned($signed(d) >>> b[5:0])
                          : {32'h0, $unsigned($signed(d32) >>> b[4:0])};
            4'h3, 4'h9: begin
                bad = (off > 16'd1);
                x = d; y = b; x32 = d32; y32 = b32;
                if (w64) begin
                    if (b == 64'h0) r = (op == 4'h3) ? 64'h0 : d;
                    else if (!sgn) r = (op == 4'h3) ? d / b : d % b;
                    else if (x == 64'sh8000_0000_0000_0000 && y == -64'sd1)
                        r = (op == 4'h3) ? 64'h8000_0000_0000_0000 : 64'h0;
                    else r = (op == 4'h3) ? 64'(x / y) : 64'(x % y);
                end else begin
                    if (b32 == 32'h0) r = (op == 4'h3) ? 64'h0 : {32'h0, d32};
                    else if (!sgn) r = {32'h0, (op == 4'h3) ? d32 / b32 : d32 % b32};
                    else if (x32 == 32'sh8000_0000 && y32 == -32'sd1)
                        r = (op == 4'h3) ? 64'h8000_0000 : 64'h0;
                    else r = {32'h0, 32'((op == 4'h3) ? x32 / y32 : x32 % y32)};
                end
            end
            4'hB: begin
                bad = 1'b0;
                case (off)
                    16'd0:  r = b;
                    16'd8:  r = {{56{b[7]}}, b[7:0]};
                    16'd16: r = {{48{b[15]}}, b[15:0]};
                    16'd32: begin r = {{32{b[31]}}, b[31:0]}; bad = !w64; end
                    default: bad = 1'b1;
                endcase
                if (!w64) r = {32'h0, r[31:0]};
            end
            4'hD: begin
                if (im != 32'd16 && im != 32'd32 && im != 32'd64) bad = 1'b1;
                if (w64 && ur) bad = 1'b1;
                nb   = int'(im) / 8;
                swap = w64 || (ur != host_be);
                for (int k = 0; k < 8; k++) begin
                    if (k < nb) r[k*8 +: 8] = swap ? d[(nb-1-k)*8 +: 8] : d[k*8 +: 8];
                end
            end
            default: bad = 1'b1;
        endcase
        if (bad) r = d;
        return {bad, r};
    endfunction

    // Requirement tag that a vector mainly exercises.
    function automatic string tag_of(input logic [3:0] op, input bit w64, input bit ur,
            input logic [15:0] off, input logic [63:0] b, input bit bad);
        if (bad) return "R9";
        case (op)
            4'hD: return "R8";
            4'hB: return "R7";
            4'h6, 4'h7, 4'hC: return "R6";
            4'h3, 4'h9: begin
                if (off == 16'd1) return "R5";
                if ((w64 ? b : {32'h0, b[31:0]}) == 64'h0) return (op == 4'h3) ? "R3" : "R4";
                return "R3";
            end
            default: return ur ? "R1" : "R2";
        endcase
    endfunction

    // Compare one output pair against the model.
    task automatic check_one(input string inst, input logic [63:0] got,
            input logic got_ill, input logic [64:0] exp, input string tag);
        checks++;
        if (got !== exp[63:0] || got_ill !== exp[64]) begin
            errors++;
            $display("FAIL %s %s op=%h wide=%0b use_reg=%0b off=%0d imm=%h dst=%h src=%h got=%h/%0b exp=%h/%0b",
                     tag, inst, op_code, wide, use_reg, offset, imm, dst_val, src_val,
                     got, got_ill, exp[63:0], exp[64]);
        end
    endtask

    // Drive one vector on the falling edge and check it shortly after.
    task automatic apply(input logic [3:0] op, input bit w64, input bit ur,
            input logic [15:0] off, input logic [31:0] im,
            input logic [63:0] d, input logic [63:0] s);
        logic [64:0] e_le, e_be;
        logic [63:0] b;
        @(negedge clk);
        op_code = op; wide = w64; use_reg = ur; offset = off;
        imm = im; dst_val = d; src_val = s;
        #1;
        e_le = model(op, w64, ur, off, im, d, s, 1'b0);
        e_be = model(op, w64, ur, off, im, d, s, 1'b1);
        b    = ur ? s : {{32{im[31]}}, im};
        check_one("le", res_le, ill_le, e_le, tag_of(op, w64, ur, off, b, e_le[64]));
        check_one("be", res_be, ill_be, e_be, tag_of(op, w64, ur, off, b, e_be[64]));
    endtask

    initial begin
        op_code = '0; wide = 1'b0; use_reg = 1'b0; offset = '0;
        imm = '0; dst_val = '0; src_val = '0;
        // Directed corners named by requirement.
        apply(4'h0, 1'b1, 1'b0, 16'd0, 32'hFFFF_FFFF, 64'h0, 64'h0);      // R2 imm -1
        apply(4'h3, 1'b0, 1'b1, 16'd1, 32'h0, 64'h8000_0000, 64'hFFFF_FFFF); // R5 min/-1
        apply(4'h9, 1'b0, 1'b1, 16'd0, 32'h0, 64'hDEAD_BEEF_0000_0007, 64'h0); // R4
        apply(4'hD, 1'b0, 1'b1, 16'd0, 32'd16, 64'h1122_3344_5566_7788, 64'h0); // R8
        apply(4'hE, 1'b1, 1'b1, 16'd0, 32'h0, 64'h55, 64'h1);               // R9
        // Sweep.
        for (int op = 0; op < 16; op++)
            for (int w = 0; w < 2; w++)
                for (int o = 0; o < 6; o++)
                    for (int di = 0; di < 8; di++)
                        for (int si = 0; si < 16; si++)
                            apply(4'(op), w[0], (si < 8), OFF_SET[o],
                                  IMM_SET[si % 8], DST_SET[di], SRC_SET[si % 8]);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule